// File: doc/BRIEF.md
# Power-Stage Protection and Burst Supervisor

This block sits between a bank of analog comparators and the gate drivers of a two-stage supply: a power-factor front stage and a flyback back stage. Every comparator reaches it as a synchronous digital level. The block qualifies each fault with its own persistence timer and sequences start-up and shutdown from the supply-rail thresholds. It tells each stage whether it may switch. It also steers the front-stage error voltage, either by a clamp request or by high/low forcing during light-load burst operation.

Most faults are handled by a hiccup. Switching stops, and the block waits until the supply has collapsed below its reset level and climbed back above its start level. Front-stage output faults are handled differently: they only hold off the front stage while they stay qualified. A line brownout works in two steps. It first asks for the error voltage to be clamped, and it stops everything only once the front-stage output has actually sagged. A 4-bit register keeps the cause of the first fault until the next power-on.

Every debounce window is a parameter counted in clock cycles. The defaults assume a 125 MHz clock and give windows from about 70 us to 100 ms.

Top module: `pwr_guard_supervisor`

## Requirements
- R1: Switching is allowed (pfc_enable high) one cycle after `vdd_gt_start` is seen in the off state. If `vdd_gt_stop` goes low while running, both enables drop at the next clock edge. A restart then requires `vdd_gt_reset` to have gone low first.
- R2: `vdd_ovp_cmp` held for T_VDD_OVP cycles stops both stages until a supply reset cycle, and records cause code 1.
- R3: `inv_high_cmp` or `inv_low_cmp` held for T_INV_FLT cycles forces pfc_enable low for as long as the level persists. pfc_enable returns one cycle after release. pwm_enable is unaffected. The recorded causes are 6 (high) and 7 (low).
- R4: pwm_enable rises only while running and only after `inv_ready_cmp` has been sampled high. Until then the back stage stays off.
- R5: `line_low_cmp` held for T_LINE_LOW cycles raises comp_clamp while running. comp_clamp drops one cycle after the line recovers.
- R6: While comp_clamp is high, `inv_collapse_cmp` stops both stages at the next edge and records cause 5. A restart then needs both a supply reset cycle and `line_rearm_cmp` high.
- R7: `fb_open_cmp` held for T_FB_OLP cycles stops both stages with auto-recovery, and records cause 3.
- R8: On the thermistor input, `rt_warm_cmp` held for T_RT_SLOW cycles trips protection. When `rt_hot_cmp` is also set, T_RT_FAST cycles suffice. Either trip records cause 4.
- R9: `det_ovp_cmp` held for T_DET_OVP cycles stops both stages and records cause 2.
- R10: `fb_light_cmp` held for T_BURST_IN cycles while running enters burst mode one cycle later, with comp_force_hi high. `fb_heavy_cmp` held for T_BURST_OUT cycles leaves it one cycle later.
- R11: In burst mode, a sample of `inv_high_cmp` switches to the low phase at the next edge: comp_force_lo high, comp_force_hi low, pfc_enable low. A sample of `inv_under_ref_cmp` switches back to the high phase.
- R12: Every debounce counter clears when its input drops before expiry. A pulse one cycle shorter than its window has no effect.
- R13: fault_cause holds the code of the first qualified fault; when several qualify in the same cycle, the lowest code wins. It is not overwritten, and it reads 0 again after the next power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vdd_gt_start | input | 1 | Supply above start level |
| vdd_gt_stop | input | 1 | Supply above switching-stop level |
| vdd_gt_reset | input | 1 | Supply above full-reset level |
| vdd_ovp_cmp | input | 1 | Supply overvoltage comparator |
| inv_high_cmp | input | 1 | Front-stage output above overvoltage level |
| inv_low_cmp | input | 1 | Front-stage output below undervoltage level |
| inv_ready_cmp | input | 1 | Front-stage output high enough for back-stage start |
| inv_collapse_cmp | input | 1 | Front-stage output below brownout stop level |
| inv_under_ref_cmp | input | 1 | Front-stage output below regulation reference |
| line_low_cmp | input | 1 | Line sense below brownout level |
| line_rearm_cmp | input | 1 | Line sense above re-arm level |
| fb_open_cmp | input | 1 | Feedback above open-loop level |
| fb_light_cmp | input | 1 | Feedback below burst-entry level |
| fb_heavy_cmp | input | 1 | Feedback above burst-exit level |
| det_ovp_cmp | input | 1 | Sampled output overvoltage comparator |
| rt_warm_cmp | input | 1 | Thermistor pin below trip level |
| rt_hot_cmp | input | 1 | Thermistor pin below fast-trip level |
| pfc_enable | output | 1 | Front stage may switch |
| pwm_enable | output | 1 | Back stage may switch |
| comp_clamp | output | 1 | Request to clamp the error voltage low |
| comp_force_hi | output | 1 | Burst high phase: drive error voltage high |
| comp_force_lo | output | 1 | Burst low phase: drive error voltage low |
| fault_cause | output | 4 | First fault code (0 none, 1..7 per requirements) |

## Verification
A broken state register shows up at the enables within one or two cycles of the stimulus. A debounce counter that does not clear, or that expires one cycle early, turns a sub-threshold pulse into a shutdown that stays visible until the next supply cycle. A lost brownout or burst flag appears as an enable or a forcing output that disagrees with the input history at the very next edge. A corrupted first-fault register is visible on fault_cause as soon as a second fault qualifies or power returns.

// File: rtl/pg_pkg.sv
// Shared state type and fault-code helpers for the protection supervisor.
// Assumes fault bits are indexed by their cause code (1..7).
package pg_pkg;
    typedef enum logic [1:0] {PS_OFF, PS_RUN, PS_HOLD} pstate_t;

    localparam int unsigned NCODE = 7;

    // Lowest-numbered asserted fault wins.
    function automatic logic [3:0] first_code(input logic [NCODE:1] f);
        logic [3:0] c;
        c = '0;
        for (int i = NCODE; i >= 1; i--) begin
            if (f[i]) c = 4'(i);
        end
        return c;
    endfunction
endpackage

// File: rtl/pg_debounce.sv
// Persistence qualifier: qual rises after LIMIT consecutive sampled-high
// cycles and stays high while level stays high. Any low sample clears it.
// Assumes LIMIT >= 1.
module pg_debounce #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic qual
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count consecutive high samples, saturating at TOP.
    always_ff @(posedge clk) begin
        if (!rst_n || !level) cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + CW'(1);
    end

    assign qual = (cnt == TOP);
endmodule

// File: rtl/pg_rt_guard.sv
// Two-level thermistor qualifier: a shallow excursion trips after SLOW
// cycles and a deep one after FAST cycles. Assumes hot implies warm.
module pg_rt_guard #(
    parameter int unsigned SLOW = 1250000,
    parameter int unsigned FAST = 13750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_trip,
    input  logic below_deep,
    output logic trip
);
    logic slow_q, fast_q;

    pg_debounce #(.LIMIT(SLOW)) u_slow (.clk(clk), .rst_n(rst_n), .level(below_trip), .qual(slow_q));
    pg_debounce #(.LIMIT(FAST)) u_fast (.clk(clk), .rst_n(rst_n), .level(below_deep), .qual(fast_q));

    assign trip = slow_q | fast_q;
endmodule

// File: rtl/pg_burst_ctrl.sv
// Light-load burst controller for the front stage. Entry and exit are
// debounced. Inside burst, the error voltage alternates between forced high
// and forced low, with the output-voltage comparators as the hysteresis band.
// Assumes run drops whenever switching is disallowed.
module pg_burst_ctrl #(
    parameter int unsigned T_IN  = 12500000,
    parameter int unsigned T_OUT = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fb_low,
    input  logic fb_high,
    input  logic inv_at_ovp,
    input  logic inv_under_ref,
    output logic force_hi,
    output logic force_lo,
    output logic pfc_hold
);
    logic active, phase_lo;
    logic in_q, out_q;

    pg_debounce #(.LIMIT(T_IN))  u_enter (.clk(clk), .rst_n(rst_n),
        .level(fb_low && run && !active), .qual(in_q));
    pg_debounce #(.LIMIT(T_OUT)) u_leave (.clk(clk), .rst_n(rst_n),
        .level(fb_high && active), .qual(out_q));

    // Burst activity and high/low phase tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            active   <= 1'b0;
            phase_lo <= 1'b0;
        end else if (!active) begin
            if (in_q) begin
                active   <= 1'b1;
                phase_lo <= 1'b0;
            end
        end else if (out_q) begin
            active   <= 1'b0;
            phase_lo <= 1'b0;
        end else if (!phase_lo && inv_at_ovp) begin
            phase_lo <= 1'b1;
        end else if (phase_lo && inv_under_ref) begin
            phase_lo <= 1'b0;
        end
    end

    assign force_hi = active && !phase_lo;
    assign force_lo = active && phase_lo;
    assign pfc_hold = active && phase_lo;
endmodule

// File: rtl/pg_sequencer.sv
// Power-state sequencer: off / running / hold. Latching faults (codes 1..5)
// move to hold, and hold is left only through a supply reset. Also tracks
// back-stage start permission, the brownout re-arm latch and the first-fault
// register. Assumes trip[] bits are already qualified.
module pg_sequencer
    import pg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vdd_start,
    input  logic             vdd_run_ok,
    input  logic             vdd_alive,
    input  logic [NCODE:1]   trip,
    input  logic             line_rearm,
    input  logic             inv_ready,
    output logic             run,
    output logic             pwm_go,
    output logic [3:0]       cause
);
    pstate_t state;
    logic    bo_latch;
    logic    latch_trip;

    assign latch_trip = |trip[5:1];

    // State, start permission, brownout latch and first-fault capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_OFF;
            bo_latch <= 1'b0;
            pwm_go   <= 1'b0;
            cause    <= '0;
        end else begin
            case (state)
                PS_OFF: begin
                    pwm_go <= 1'b0;
                    if (vdd_start && (!bo_latch || line_rearm)) begin
                        state    <= PS_RUN;
                        bo_latch <= 1'b0;
                        cause    <= '0;
                    end
                end
                PS_RUN: begin
                    if (cause == 4'd0 && |trip) cause <= first_code(trip);
                    if (!vdd_run_ok || latch_trip) begin
                        state  <= PS_HOLD;
                        pwm_go <= 1'b0;
                        if (trip[5]) bo_latch <= 1'b1;
                    end else if (inv_ready) begin
                        pwm_go <= 1'b1;
                    end
                end
                default: begin
                    pwm_go <= 1'b0;
                    if (!vdd_alive) state <= PS_OFF;
                end
            endcase
        end
    end

    assign run = (state == PS_RUN);
endmodule

// File: rtl/pwr_guard_supervisor.sv
// Top of the protection and burst supervisor. Debounces the simple fault
// comparators with a generated bank of timers, then combines them with the
// thermistor guard, the burst controller and the sequencer. Assumes all
// comparator inputs are synchronous to clk.
module pwr_guard_supervisor
    import pg_pkg::*;
#(
    parameter int unsigned T_VDD_OVP   = 18750,
    parameter int unsigned T_INV_FLT   = 8750,
    parameter int unsigned T_LINE_LOW  = 12500000,
    parameter int unsigned T_FB_OLP    = 6250000,
    parameter int unsigned T_RT_SLOW   = 1250000,
    parameter int unsigned T_RT_FAST   = 13750,
    parameter int unsigned T_DET_OVP   = 18750,
    parameter int unsigned T_BURST_IN  = 12500000,
    parameter int unsigned T_BURST_OUT = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vdd_gt_start,
    input  logic       vdd_gt_stop,
    input  logic       vdd_gt_reset,
    input  logic       vdd_ovp_cmp,
    input  logic       inv_high_cmp,
    input  logic       inv_low_cmp,
    input  logic       inv_ready_cmp,
    input  logic       inv_collapse_cmp,
    input  logic       inv_under_ref_cmp,
    input  logic       line_low_cmp,
    input  logic       line_rearm_cmp,
    input  logic       fb_open_cmp,
    input  logic       fb_light_cmp,
    input  logic       fb_heavy_cmp,
    input  logic       det_ovp_cmp,
    input  logic       rt_warm_cmp,
    input  logic       rt_hot_cmp,
    output logic       pfc_enable,
    output logic       pwm_enable,
    output logic       comp_clamp,
    output logic       comp_force_hi,
    output logic       comp_force_lo,
    output logic [3:0] fault_cause
);
    localparam int unsigned NSIMPLE = 6;
    localparam int unsigned LIMS [NSIMPLE] = '{T_VDD_OVP, T_DET_OVP, T_FB_OLP,
                                               T_INV_FLT, T_INV_FLT, T_LINE_LOW};

    logic [NSIMPLE-1:0] raw, qual;
    logic [NCODE:1]     trip;
    logic               rt_trip, run, pwm_go, burst_hold;

    assign raw = {line_low_cmp, inv_low_cmp, inv_high_cmp,
                  fb_open_cmp, det_ovp_cmp, vdd_ovp_cmp};

    // One persistence timer per simple fault.
    for (genvar i = 0; i < NSIMPLE; i++) begin : g_deb
        pg_debounce #(.LIMIT(LIMS[i])) u_deb (
            .clk(clk), .rst_n(rst_n), .level(raw[i]), .qual(qual[i]));
    end

    pg_rt_guard #(.SLOW(T_RT_SLOW), .FAST(T_RT_FAST)) u_rt (
        .clk(clk), .rst_n(rst_n), .below_trip(rt_warm_cmp),
        .below_deep(rt_hot_cmp), .trip(rt_trip));

    // Fault vector indexed by cause code.
    always_comb begin
        trip    = '0;
        trip[1] = qual[0];
        trip[2] = qual[1];
        trip[3] = qual[2];
        trip[4] = rt_trip;
        trip[5] = qual[5] && inv_collapse_cmp;
        trip[6] = qual[3];
        trip[7] = qual[4];
    end

    pg_burst_ctrl #(.T_IN(T_BURST_IN), .T_OUT(T_BURST_OUT)) u_burst (
        .clk(clk), .rst_n(rst_n), .run(run), .fb_low(fb_light_cmp),
        .fb_high(fb_heavy_cmp), .inv_at_ovp(inv_high_cmp),
        .inv_under_ref(inv_under_ref_cmp), .force_hi(comp_force_hi),
        .force_lo(comp_force_lo), .pfc_hold(burst_hold));

    pg_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .vdd_start(vdd_gt_start),
        .vdd_run_ok(vdd_gt_stop), .vdd_alive(vdd_gt_reset), .trip(trip),
        .line_rearm(line_rearm_cmp), .inv_ready(inv_ready_cmp),
        .run(run), .pwm_go(pwm_go), .cause(fault_cause));

    assign pfc_enable = run && !trip[6] && !trip[7] && !burst_hold;
    assign pwm_enable = run && pwm_go;
    assign comp_clamp = run && qual[5];
endmodule

// File: rtl/pg_supervisor_chk.sv
// Checker for pwr_guard_supervisor, attached by bind.
module pg_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vdd_gt_start,
    input logic       vdd_gt_stop,
    input logic       inv_ready_cmp,
    input logic       line_low_cmp,
    input logic       pfc_enable,
    input logic       pwm_enable,
    input logic       comp_clamp,
    input logic       comp_force_lo,
    input logic [3:0] fault_cause
);
    AST_LOW_SUPPLY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!vdd_gt_stop && !vdd_gt_start) |=> (!pfc_enable && !pwm_enable)); // R1

    AST_PWM_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_enable) |-> $past(inv_ready_cmp)); // R4

    AST_CLAMP_NEEDS_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        comp_clamp |-> $past(line_low_cmp)); // R5

    AST_LOW_PHASE_HOLDS_PFC: assert property (@(posedge clk) disable iff (!rst_n)
        comp_force_lo |-> !pfc_enable); // R11

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_cause) != 4'd0 && fault_cause != $past(fault_cause))
            |-> fault_cause == 4'd0); // R13
endmodule

bind pwr_guard_supervisor pg_supervisor_chk u_chk (.*);

// File: tb/sim_pwr_guard_supervisor.sv
module sim_pwr_guard_supervisor;
    localparam int unsigned TV = 6, TI = 5, TL = 12, TO = 10, TS = 16,
                            TF = 4, TD = 6, TBI = 10, TBO = 5;

    logic clk = 0, rst_n = 0;
    logic vdd_gt_start = 0, vdd_gt_stop = 0, vdd_gt_reset = 0, vdd_ovp_cmp = 0;
    logic inv_high_cmp = 0, inv_low_cmp = 0, inv_ready_cmp = 0, inv_collapse_cmp = 0;
    logic inv_under_ref_cmp = 0, line_low_cmp = 0, line_rearm_cmp = 1;
    logic fb_open_cmp = 0, fb_light_cmp = 0, fb_heavy_cmp = 1, det_ovp_cmp = 0;
    logic rt_warm_cmp = 0, rt_hot_cmp = 0;
    logic pfc_enable, pwm_enable, comp_clamp, comp_force_hi, comp_force_lo;
    logic [3:0] fault_cause;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    pwr_guard_supervisor #(.T_VDD_OVP(TV), .T_INV_FLT(TI), .T_LINE_LOW(TL),
        .T_FB_OLP(TO), .T_RT_SLOW(TS), .T_RT_FAST(TF), .T_DET_OVP(TD),
        .T_BURST_IN(TBI), .T_BURST_OUT(TBO)) u0 (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic power_up;
        vdd_gt_start = 1; vdd_gt_stop = 1; vdd_gt_reset = 1; inv_ready_cmp = 1;
        tick(3);
    endtask

    task automatic power_cycle;
        vdd_gt_start = 0; vdd_gt_stop = 0; vdd_gt_reset = 0;
        tick(2);
        power_up();
    endtask

    // Hold a latching fault for len cycles and compare against its window.
    task automatic latch_sweep(input int sel, input int len, input int win,
                               input int code, input string req);
        power_cycle();
        case (sel)
            0: vdd_ovp_cmp = 1;
            1: det_ovp_cmp = 1;
            2: fb_open_cmp = 1;
            3: rt_warm_cmp = 1;
            default: begin rt_warm_cmp = 1; rt_hot_cmp = 1; end
        endcase
        tick(len);
        vdd_ovp_cmp = 0; det_ovp_cmp = 0; fb_open_cmp = 0;
        rt_warm_cmp = 0; rt_hot_cmp = 0;
        tick(2);
        chk(pwm_enable == (len < win), req, $sformatf("pwm after pulse %0d", len),
            pwm_enable, len < win);
        chk(fault_cause == ((len < win) ? 4'd0 : 4'(code)), req, "cause",
            fault_cause, (len < win) ? 0 : code);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual expired expected finish");
        summary();
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        chk(!pfc_enable && !pwm_enable && !comp_clamp && !comp_force_hi &&
            !comp_force_lo, "R1", "reset outputs", pfc_enable, 0);
        chk(fault_cause == 0, "R13", "reset cause", fault_cause, 0);

        // R1 start and R4 gating by front-stage level
        vdd_gt_start = 1; vdd_gt_stop = 1; vdd_gt_reset = 1;
        tick(1);
        chk(pfc_enable == 1, "R1", "pfc one cycle after start", pfc_enable, 1);
        tick(3);
        chk(pwm_enable == 0, "R4", "pwm waits for ready", pwm_enable, 0);
        inv_ready_cmp = 1;
        tick(1);
        chk(pwm_enable == 1, "R4", "pwm after ready", pwm_enable, 1);

        // R1 stop level, then no restart without reset level dropping
        vdd_gt_start = 0; vdd_gt_stop = 0;
        tick(1);
        chk(!pfc_enable && !pwm_enable, "R1", "stop level", pfc_enable, 0);
        vdd_gt_start = 1; vdd_gt_stop = 1;
        tick(3);
        chk(pfc_enable == 0, "R1", "no restart without reset", pfc_enable, 0);
        chk(fault_cause == 0, "R1", "undervoltage is not a fault", fault_cause, 0);
        power_cycle();
        chk(pfc_enable && pwm_enable, "R1", "restart after reset", pfc_enable, 1);

        // R2, R9, R7, R8 with R12 sweeps around each window
        for (int l = 1; l <= int'(TV) + 2; l++) latch_sweep(0, l, TV, 1, "R2 R12");
        for (int l = int'(TD) - 1; l <= int'(TD); l++) latch_sweep(1, l, TD, 2, "R9");
        for (int l = int'(TO) - 1; l <= int'(TO); l++) latch_sweep(2, l, TO, 3, "R7");
        for (int l = int'(TS) - 1; l <= int'(TS); l++) latch_sweep(3, l, TS, 4, "R8 slow");
        for (int l = 1; l <= int'(TF) + 1; l++) latch_sweep(4, l, TF, 4, "R8 fast");

        // R3 front-stage output faults, both polarities
        for (int s = 0; s < 2; s++) begin
            for (int l = 1; l <= int'(TI) + 2; l++) begin
                power_cycle();
                if (s == 0) inv_high_cmp = 1; else inv_low_cmp = 1;
                tick(l);
                chk(pfc_enable == (l < int'(TI)), "R3 R12",
                    $sformatf("pfc during pulse %0d", l), pfc_enable, l < int'(TI));
                chk(pwm_enable == 1, "R3", "pwm unaffected", pwm_enable, 1);
                inv_high_cmp = 0; inv_low_cmp = 0;
                tick(1);
                chk(pfc_enable == 1, "R3", "pfc back after release", pfc_enable, 1);
                chk(fault_cause == ((l < int'(TI)) ? 4'd0 : 4'(6 + s)), "R13",
                    "cause inv", fault_cause, (l < int'(TI)) ? 0 : 6 + s);
            end
        end

        // R13 simultaneous faults: lowest code, then sticky
        power_cycle();
        vdd_ovp_cmp = 1; det_ovp_cmp = 1;
        tick(int'(TV) + 1);
        chk(fault_cause == 1, "R13", "priority", fault_cause, 1);
        vdd_ovp_cmp = 0; det_ovp_cmp = 0; fb_open_cmp = 1;
        tick(int'(TO) + 2);
        fb_open_cmp = 0;
        chk(fault_cause == 1, "R13", "sticky", fault_cause, 1);

        // R5 / R6 two-step brownout
        power_cycle();
        chk(fault_cause == 0, "R13", "cleared at power-on", fault_cause, 0);
        line_low_cmp = 1;
        tick(int'(TL) - 1);
        chk(comp_clamp == 0, "R5", "clamp before window", comp_clamp, 0);
        tick(1);
        chk(comp_clamp == 1, "R5", "clamp at window", comp_clamp, 1);
        chk(pwm_enable == 1, "R5", "clamp alone keeps running", pwm_enable, 1);
        inv_collapse_cmp = 1;
        tick(1);
        chk(!pfc_enable && !pwm_enable, "R6", "brownout stop", pwm_enable, 0);
        chk(fault_cause == 5, "R6", "brownout cause", fault_cause, 5);
        line_low_cmp = 0; inv_collapse_cmp = 0; line_rearm_cmp = 0;
        power_cycle();
        chk(pfc_enable == 0, "R6", "no restart without rearm", pfc_enable, 0);
        line_rearm_cmp = 1;
        tick(1);
        chk(pfc_enable == 1, "R6", "restart after rearm", pfc_enable, 1);

        // R5 clamp drops after line recovers
        line_low_cmp = 1;
        tick(int'(TL));
        line_low_cmp = 0;
        tick(1);
        chk(comp_clamp == 0, "R5", "clamp release", comp_clamp, 0);

        // R10 / R11 burst
        power_cycle();
        fb_heavy_cmp = 0; fb_light_cmp = 1;
        tick(int'(TBI));
        chk(comp_force_hi == 0, "R10", "not yet in burst", comp_force_hi, 0);
        tick(1);
        chk(comp_force_hi == 1, "R10", "burst entry", comp_force_hi, 1);
        inv_high_cmp = 1;
        tick(1);
        inv_high_cmp = 0;
        chk(comp_force_lo && !comp_force_hi, "R11", "low phase", comp_force_lo, 1);
        chk(pfc_enable == 0, "R11", "pfc stops in low phase", pfc_enable, 0);
        tick(2);
        chk(comp_force_lo == 1, "R11", "low phase holds", comp_force_lo, 1);
        inv_under_ref_cmp = 1;
        tick(1);
        inv_under_ref_cmp = 0;
        chk(comp_force_hi && pfc_enable, "R11", "high phase again", comp_force_hi, 1);
        fb_light_cmp = 0; fb_heavy_cmp = 1;
        tick(int'(TBO));
        chk(comp_force_hi == 1, "R10", "still in burst", comp_force_hi, 1);
        tick(1);
        chk(!comp_force_hi && !comp_force_lo, "R10", "burst exit", comp_force_hi, 0);

        summary();
    end
endmodule